// File: doc/BRIEF.md
# Write-Snooping Sprite Attribute Cache

This block holds a private copy of the leading bytes of every entry in the sprite attribute table. It never fetches from video memory. It watches each byte-wide write to video memory. When the written address lands on a cached byte of the table, as placed by the table base register at that moment, the block copies the byte into its own storage. Moving the base does not reload anything. Entries keep whatever was captured under the earlier placement until fresh writes reach the new one.

The sprite scanner walks the cache through two read ports, which fetch two entries per request. This fits a sprite pattern slot that consumes two entries. The number of entries, the entry stride, the number of cached bytes per entry, the address width and the base alignment are all parameters.

Top module: `satc_cache`

## Requirements
- R1: While `rst_n` is low at a clock edge, every cached byte becomes 0x00 and `rd_valid_o` goes low.
- R2: A write is a hit when all of the following hold:
  - `vw_en_i` is high.
  - `off = (vw_addr_i - (tbl_base_i << BASE_SHIFT)) mod 2^ADDR_W` is below `NUM_ENTRIES*ENTRY_BYTES`.
  - `off mod ENTRY_BYTES` is below `CACHED_BYTES`.

  On a hit, the byte is stored in entry `off / ENTRY_BYTES`. Byte k of the entry sits at bits `[8*(CACHED_BYTES-1-k) +: 8]`, so the even address of each 16-bit pair fills the high byte.
- R3: A write changes only its single target byte. Writes to uncached bytes of an entry (offset within entry ≥ `CACHED_BYTES`) and writes outside the window change nothing.
- R4: Changing `tbl_base_i` alone never alters cache contents. Data captured under an old base stays readable.
- R5: The window for a write is set by the value of `tbl_base_i` in the same cycle as that write.
- R6: The window wraps modulo the address space. A table placed near the top of memory continues at address 0.
- R7: When `rd_en_i` is high at an edge, `rd_data_a_o` and `rd_data_b_o` present the entries at `rd_idx_a_i` and `rd_idx_b_i` from that edge onward, and `rd_valid_o` is high for exactly that next cycle.
- R8: If a read and a hitting write target the same entry at the same edge, the read returns the data from before the write. A later read returns the new data.
- R9: A read index ≥ `NUM_ENTRIES` returns all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_base_i | input | ADDR_W-BASE_SHIFT | Table base, in units of 2^BASE_SHIFT bytes |
| vw_en_i | input | 1 | Video memory byte write strobe |
| vw_addr_i | input | ADDR_W | Byte address of the write |
| vw_data_i | input | 8 | Byte written |
| rd_en_i | input | 1 | Scanner read request |
| rd_idx_a_i | input | IDX_W | First entry index |
| rd_idx_b_i | input | IDX_W | Second entry index |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_a_o | output | 8*CACHED_BYTES | First entry data |
| rd_data_b_o | output | 8*CACHED_BYTES | Second entry data |

## Verification
The bench uses a small configuration and writes every address of the space with an address-derived byte. This separates hits from uncached bytes and from out-of-window addresses, and catches lane or entry misplacement.

It then moves the base without writing, to show that stale data is retained. It also changes the base in the same cycle as a write, to show the window tracks the current base. A base near the top of memory exercises the wrap to address 0.

Finally, a read and a write aimed at one entry in the same cycle separate old-data from new-data return. Out-of-range indices confirm the zero result.

// File: rtl/satc_pkg.sv
// Package: shared helpers for the sprite attribute snoop cache.
// Assumes bytes are numbered from the entry start, byte 0 in the top lane.
package satc_pkg;

    typedef logic [7:0] byte_t;

    // Bit position of byte k within an entry of n cached bytes.
    function automatic int unsigned lane_lsb(input int unsigned k, input int unsigned n);
        return 8 * (n - 1 - k);
    endfunction

endpackage

// File: rtl/satc_window_decode.sv
// Module: satc_window_decode
// Maps a video memory byte write onto a cache entry and byte using the
// current table base. Purely combinational; the window wraps modulo 2^ADDR_W.
// Assumes ENTRY_BYTES and CACHED_BYTES are powers of two, CACHED_BYTES <= ENTRY_BYTES.
module satc_window_decode #(
    parameter int unsigned ADDR_W       = 16,
    parameter int unsigned BASE_SHIFT   = 9,
    parameter int unsigned NUM_ENTRIES  = 80,
    parameter int unsigned ENTRY_BYTES  = 8,
    parameter int unsigned CACHED_BYTES = 4,
    localparam int unsigned BASE_W      = ADDR_W - BASE_SHIFT,
    localparam int unsigned IDX_W       = $clog2(NUM_ENTRIES),
    localparam int unsigned CB_W        = (CACHED_BYTES > 1) ? $clog2(CACHED_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BASE_W-1:0] base_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  entry_o,
    output logic [CB_W-1:0]   byte_o
);
    localparam int unsigned LOG_EB      = $clog2(ENTRY_BYTES);
    localparam int unsigned TABLE_BYTES = NUM_ENTRIES * ENTRY_BYTES;

    logic [ADDR_W-1:0] win_lo;
    logic [ADDR_W-1:0] offs;
    logic [LOG_EB-1:0] in_entry;
    logic              in_table;
    logic              cached;

    // Window start and write offset, wrapping modulo the address space.
    always_comb begin
        win_lo   = {base_i, {BASE_SHIFT{1'b0}}};
        offs     = wr_addr_i - win_lo;
        in_entry = offs[LOG_EB-1:0];
        in_table = (32'(offs) < TABLE_BYTES);
        cached   = (32'(in_entry) < CACHED_BYTES);
    end

    // Hit qualification and the entry/byte coordinates of the write.
    always_comb begin
        hit_o   = wr_en_i && in_table && cached;
        entry_o = IDX_W'(offs >> LOG_EB);
        byte_o  = CB_W'(in_entry);
    end

    // R2
    hit_entry_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (32'(entry_o) < NUM_ENTRIES));

    // R3
    miss_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |-> !hit_o);
endmodule

// File: rtl/satc_entry_store.sv
// Module: satc_entry_store
// Entry storage with one byte-wide write port and a parameterised number
// of registered read ports. A read in the same cycle as a write to the same
// entry returns the data held before that write.
// Assumes the write index is in range whenever w_en_i is high.
module satc_entry_store
    import satc_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES  = 80,
    parameter int unsigned CACHED_BYTES = 4,
    parameter int unsigned NUM_RD       = 2,
    localparam int unsigned IDX_W       = $clog2(NUM_ENTRIES),
    localparam int unsigned CB_W        = (CACHED_BYTES > 1) ? $clog2(CACHED_BYTES) : 1,
    localparam int unsigned EW          = 8 * CACHED_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             w_en_i,
    input  logic [IDX_W-1:0] w_idx_i,
    input  logic [CB_W-1:0]  w_byte_i,
    input  byte_t            w_data_i,
    input  logic             rd_en_i,
    input  logic [IDX_W-1:0] rd_idx_i  [NUM_RD],
    output logic [EW-1:0]    rd_data_o [NUM_RD]
);
    logic [EW-1:0] mem_q [NUM_ENTRIES];

    // Byte update of the addressed entry; clear all entries on reset.
    always_ff @(posedge clk) begin
        for (int i = 0; i < int'(NUM_ENTRIES); i++) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else if (w_en_i && (w_idx_i == IDX_W'(i))) begin
                mem_q[i][lane_lsb(int'(w_byte_i), CACHED_BYTES) +: 8] <= w_data_i;
            end
        end
    end

    for (genvar gp = 0; gp < int'(NUM_RD); gp++) begin : g_rd
        // Registered read; out-of-range indices yield zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_data_o[gp] <= '0;
            end else if (rd_en_i) begin
                if (32'(rd_idx_i[gp]) < NUM_ENTRIES) begin
                    rd_data_o[gp] <= mem_q[rd_idx_i[gp]];
                end else begin
                    rd_data_o[gp] <= '0;
                end
            end
        end

        // R9
        rd_oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en_i && (32'(rd_idx_i[gp]) >= NUM_ENTRIES)) |=> (rd_data_o[gp] == '0));

        for (genvar ge = 0; ge < int'(NUM_ENTRIES); ge++) begin : g_ent
            // R8
            rd_old_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en_i && (rd_idx_i[gp] == IDX_W'(ge))) |=> (rd_data_o[gp] == $past(mem_q[ge])));
        end
    end

    for (genvar ge = 0; ge < int'(NUM_ENTRIES); ge++) begin : g_hold
        // R4
        entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(w_en_i && (w_idx_i == IDX_W'(ge))) |=> $stable(mem_q[ge]));
    end
endmodule

// File: rtl/satc_cache.sv
// Module: satc_cache
// Top of the write-snooping sprite attribute cache. Video memory byte
// writes are decoded against the live table base and copied into the
// entry store; the scanner reads two entries per request.
// Assumes one video memory byte write per cycle at most; no refill ever occurs.
module satc_cache
    import satc_pkg::*;
#(
    parameter int unsigned ADDR_W       = 16,
    parameter int unsigned BASE_SHIFT   = 9,
    parameter int unsigned NUM_ENTRIES  = 80,
    parameter int unsigned ENTRY_BYTES  = 8,
    parameter int unsigned CACHED_BYTES = 4,
    localparam int unsigned BASE_W      = ADDR_W - BASE_SHIFT,
    localparam int unsigned IDX_W       = $clog2(NUM_ENTRIES),
    localparam int unsigned EW          = 8 * CACHED_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BASE_W-1:0] tbl_base_i,
    input  logic              vw_en_i,
    input  logic [ADDR_W-1:0] vw_addr_i,
    input  logic [7:0]        vw_data_i,
    input  logic              rd_en_i,
    input  logic [IDX_W-1:0]  rd_idx_a_i,
    input  logic [IDX_W-1:0]  rd_idx_b_i,
    output logic              rd_valid_o,
    output logic [EW-1:0]     rd_data_a_o,
    output logic [EW-1:0]     rd_data_b_o
);
    localparam int unsigned NUM_RD = 2;
    localparam int unsigned CB_W   = (CACHED_BYTES > 1) ? $clog2(CACHED_BYTES) : 1;

    logic             hit;
    logic [IDX_W-1:0] hit_entry;
    logic [CB_W-1:0]  hit_byte;
    logic [IDX_W-1:0] rd_idx  [NUM_RD];
    logic [EW-1:0]    rd_data [NUM_RD];

    satc_window_decode #(
        .ADDR_W       (ADDR_W),
        .BASE_SHIFT   (BASE_SHIFT),
        .NUM_ENTRIES  (NUM_ENTRIES),
        .ENTRY_BYTES  (ENTRY_BYTES),
        .CACHED_BYTES (CACHED_BYTES)
    ) decode_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_i    (tbl_base_i),
        .wr_en_i   (vw_en_i),
        .wr_addr_i (vw_addr_i),
        .hit_o     (hit),
        .entry_o   (hit_entry),
        .byte_o    (hit_byte)
    );

    // Gather the two scanner indices into the store's port array.
    always_comb begin
        rd_idx[0] = rd_idx_a_i;
        rd_idx[1] = rd_idx_b_i;
    end

    satc_entry_store #(
        .NUM_ENTRIES  (NUM_ENTRIES),
        .CACHED_BYTES (CACHED_BYTES),
        .NUM_RD       (NUM_RD)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .w_en_i    (hit),
        .w_idx_i   (hit_entry),
        .w_byte_i  (hit_byte),
        .w_data_i  (byte_t'(vw_data_i)),
        .rd_en_i   (rd_en_i),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data)
    );

    // Spread the store's read results onto the named ports.
    always_comb begin
        rd_data_a_o = rd_data[0];
        rd_data_b_o = rd_data[1];
    end

    // One-cycle valid that follows each read request.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid_o <= 1'b0;
        else        rd_valid_o <= rd_en_i;
    end

    // R7
    rd_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rd_valid_o);

    // R7
    rd_valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> !rd_valid_o);

    // R1
    reset_valid_low_chk: assert property (@(posedge clk)
        !rst_n |=> !rd_valid_o);
endmodule

// File: tb/satc_cache_tb_top.sv
// Bench: sweeps a small cache configuration and checks every entry against
// a byte model built from the window arithmetic of the requirements.
module satc_cache_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int BS = 6;
    localparam int NE = 12;
    localparam int EB = 8;
    localparam int CB = 4;
    localparam int IW = $clog2(NE);
    localparam int BW = AW - BS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [BW-1:0] base = '0;
    logic          vw_en = 1'b0;
    logic [AW-1:0] vw_addr = '0;
    logic [7:0]    vw_data = '0;
    logic          rd_en = 1'b0;
    logic [IW-1:0] idx_a = '0;
    logic [IW-1:0] idx_b = '0;
    logic          rd_valid;
    logic [31:0]   rd_a;
    logic [31:0]   rd_b;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [7:0] model [NE][CB];

    always #(CLK_PERIOD/2) clk = ~clk;

    satc_cache #(
        .ADDR_W(AW), .BASE_SHIFT(BS), .NUM_ENTRIES(NE),
        .ENTRY_BYTES(EB), .CACHED_BYTES(CB)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tbl_base_i(base),
        .vw_en_i(vw_en), .vw_addr_i(vw_addr), .vw_data_i(vw_data),
        .rd_en_i(rd_en), .rd_idx_a_i(idx_a), .rd_idx_b_i(idx_b),
        .rd_valid_o(rd_valid), .rd_data_a_o(rd_a), .rd_data_b_o(rd_b)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_entry(input int i);
        if (i >= NE) return 32'h0;
        return {model[i][0], model[i][1], model[i][2], model[i][3]};
    endfunction

    // Model update following the window rule, wrap included.
    task automatic model_write(input int a, input logic [7:0] d, input int b);
        int off = (a - (b << BS)) & ((1 << AW) - 1);
        if (off < NE*EB && (off % EB) < CB) model[off/EB][off%EB] = d;
    endtask

    task automatic do_write(input int a, input logic [7:0] d);
        @(negedge clk);
        vw_en = 1'b1; vw_addr = AW'(a); vw_data = d;
        model_write(a, d, int'(base));
        @(posedge clk); #1;
        vw_en = 1'b0;
    endtask

    task automatic read_pair(input int ia, input int ib, input string req);
        @(negedge clk);
        rd_en = 1'b1; idx_a = IW'(ia); idx_b = IW'(ib);
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        chk(rd_valid == 1'b1, "R7 valid", 32'(rd_valid), 32'h1);
        chk(rd_a == exp_entry(ia), req, rd_a, exp_entry(ia));
        chk(rd_b == exp_entry(ib), req, rd_b, exp_entry(ib));
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < NE; i += 2) read_pair(i, i + 1, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NE; i++) for (int k = 0; k < CB; k++) model[i][k] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R1 valid low", 32'(rd_valid), 32'h0);
        rst_n = 1'b1;
        check_all("R1 cleared");

        // R2/R3: exhaustive sweep of the address space under base 3.
        base = BW'(3);
        for (int a = 0; a < (1 << AW); a++) do_write(a, 8'((a * 37 + 5) & 8'hFF));
        check_all("R2 sweep");

        // R3: uncached byte and just-outside addresses leave entry 0 alone.
        do_write((3 << BS) + 5, 8'hEE);
        do_write((3 << BS) - 1, 8'hDD);
        do_write((3 << BS) + NE*EB, 8'hCC);
        read_pair(0, NE - 1, "R3 ignored");
        // R3: single byte write touches only that byte.
        do_write((3 << BS) + 8*4 + 2, 8'h5A);
        read_pair(4, 5, "R3 one byte");

        // R4: base move with no writes keeps stale data.
        @(negedge clk); base = BW'(20);
        repeat (4) @(posedge clk);
        check_all("R4 stale");

        // R5: write uses the base presented in its own cycle.
        do_write((20 << BS) + 2*EB + 1, 8'h11);
        @(negedge clk);
        base = BW'(21); vw_en = 1'b1; vw_addr = AW'((21 << BS) + 6*EB + 3); vw_data = 8'h22;
        model_write((21 << BS) + 6*EB + 3, 8'h22, 21);
        @(posedge clk); #1; vw_en = 1'b0;
        read_pair(2, 6, "R5 live base");

        // R6: table near the top wraps to address 0.
        @(negedge clk); base = BW'(63);
        do_write(12'hFC0, 8'h31);
        do_write(12'h000, 8'h32);
        do_write(12'h019, 8'h33);
        do_write(12'h020, 8'h34);
        check_all("R6 wrap");

        // R8: same-cycle read and write of one entry.
        @(negedge clk);
        vw_en = 1'b1; vw_addr = AW'(12'hFC0 + 3*EB + 2); vw_data = 8'h99;
        rd_en = 1'b1; idx_a = IW'(3); idx_b = IW'(3);
        @(posedge clk);
        @(negedge clk);
        vw_en = 1'b0; rd_en = 1'b0;
        chk(rd_a == exp_entry(3), "R8 old data", rd_a, exp_entry(3));
        model_write(12'hFC0 + 3*EB + 2, 8'h99, 63);
        read_pair(3, 3, "R8 new data");

        // R9: out-of-range indices.
        read_pair(12, 15, "R9 zero");

        // R7: valid drops after an idle cycle.
        @(negedge clk);
        chk(rd_valid == 1'b0, "R7 valid drop", 32'(rd_valid), 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule